// File: doc/BRIEF.md
# Counterflow Ring Test Monitor

This block sits beside a pair of rings of identical stages in which items travel in opposite directions (north and south). It does not move items. It watches one chosen boundary on each ring and counts how many times that ring's marked item crosses it. The count goes into a 48-bit lap counter for each ring. The low bits of both counters are also driven on dedicated pins, so throughput can be measured off-chip. The block also owns the rings' run enable. It starts the rings on request and stops them cleanly. It reports "stopped" only once the rings have gone quiet.

A simple register bus gives full access while the rings are halted. Each stage side is reached by writing or reading its item word at address `stage*2 + dir`. An item word holds the full flag, the marker bit, the count field and the address tag. Writes go out as a one-cycle load strobe to the ring. Reads select the addressed word from the state vector the ring exports. Four further addresses give access to the low and high halves of each lap counter.

A test loads both rings with exactly one marked item per ring, then runs them, stops them and reads everything back. The lap counts and the final item positions then give the expected count value of every item. Bus writes made while the rings are not halted are dropped and raise a sticky error flag.

Top module: `cfmon_top`

## Requirements
- R1: After reset the rings are halted: `stopped`=1, `run_en`=0, `wr_err`=0, `stg_ld`=0, and both lap counters read 0.
- R2: A ring's lap counter rises by exactly one on each clock edge where that ring's `ring_cross` and `ring_cross_mark` are both 1. A crossing with the marker clear leaves the counter unchanged.
- R3: The two lap counters are independent. Index 0 of `ring_cross`/`ring_cross_mark` is the north ring and index 1 is the south ring. Activity on one ring never changes the other ring's counter.
- R4: When `run_req` is low at a clock edge, `run_en` is 0 after that edge. `stopped` rises only after two consecutive edges in the drain phase with `ring_grant_any` low. Any grant restarts the quiet count.
- R5: When `run_req` is high at a clock edge, `run_en` is 1 and `stopped` is 0 after that edge.
- R6: A bus write to address `a` < 56 while stopped produces a one-cycle `stg_ld` pulse after the edge, with `stg_ld_idx`=a>>1, `stg_ld_dir`=a[0] (0 north, 1 south) and `stg_ld_word`=wdata[8:0]. Word layout: [1:0] address tag, [6:2] count, [7] marker, [8] full.
- R7: A bus read of address `a` < 56 returns, one edge later on `bus_rdata`, item word `a` of `ring_state` (bits a*9 .. a*9+8), zero-extended.
- R8: Addresses 64/65 hold the north counter's bits [31:0]/[47:32], and 66/67 hold the south counter's. Each half is writable while stopped and readable at any time with one-edge read latency. The high half is zero-extended.
- R9: A bus write while `stopped`=0 changes no counter, produces no `stg_ld`, and sets `wr_err`, which stays set until reset.
- R10: `tap_n` and `tap_s` always equal the low 4 bits of the north and south lap counters.
- R11: A lap counter is one 48-bit value: an increment from lower half 0xFFFFFFFF carries into the upper half.
- R12: Reads of addresses 56..63 or 68..127 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | External run request; low requests a clean stop |
| run_en | output | 1 | Move enable to both rings |
| stopped | output | 1 | Rings halted and quiet; bus writes allowed |
| ring_grant_any | input | 1 | Some move grant was issued this cycle in either ring |
| ring_cross | input | 2 | Item crossed the monitored boundary ([0] north, [1] south) |
| ring_cross_mark | input | 2 | Marker bit of the crossing item |
| ring_state | input | 504 | All 56 item words from the rings, word k at bits k*9 +: 9 |
| stg_ld | output | 1 | One-cycle stage load strobe |
| stg_ld_idx | output | 5 | Stage index to load |
| stg_ld_dir | output | 1 | Side to load (0 north, 1 south) |
| stg_ld_word | output | 9 | Item word to load |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one edge after the read |
| wr_err | output | 1 | Sticky flag: write attempted while not stopped |
| tap_n | output | 4 | Low bits of the north lap counter |
| tap_s | output | 4 | Low bits of the south lap counter |

## Verification
The assertions assume that the rings obey the stop protocol: they raise `ring_grant_any` for every move they make, and they issue no crossing once `stopped` is high. They also assume that the bus never writes a counter in the same cycle as that ring's marked crossing. The bench keeps to these rules. It drives crossings only while the rings run, and it raises grants only in the drain window it is testing. Bus writes that are meant to be accepted are issued only after `stopped` has been observed high.

// File: rtl/cfmon_pkg.sv
package cfmon_pkg;

   localparam int NUM_RINGS = 2;
   localparam int RING_N    = 0;
   localparam int RING_S    = 1;

   typedef enum logic [1:0] {
      RS_RUN   = 2'd0,
      RS_DRAIN = 2'd1,
      RS_HALT  = 2'd2
   } run_state_e;

   typedef enum logic [1:0] {
      BK_NONE  = 2'd0,
      BK_STAGE = 2'd1,
      BK_CTR   = 2'd2
   } bus_kind_e;

endpackage

// File: rtl/cfmon_run_ctl.sv
module cfmon_run_ctl
   import cfmon_pkg::*;
#(
   parameter int QUIET_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_req,
   input  logic grant_any,
   output logic run_en,
   output logic stopped
);

   localparam int QC_W = $clog2(QUIET_CYC + 1);

   run_state_e          state_q;
   logic [QC_W-1:0]     quiet_q;

   generate
      if (QUIET_CYC < 1) begin : g_bad_quiet
         $error("cfmon_run_ctl: QUIET_CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RS_HALT;
         quiet_q <= '0;
      end else if (run_req) begin
         state_q <= RS_RUN;
         quiet_q <= '0;
      end else begin
         unique case (state_q)
            RS_RUN: begin
               state_q <= RS_DRAIN;
               quiet_q <= '0;
            end
            RS_DRAIN: begin
               if (grant_any) begin
                  quiet_q <= '0;
               end else if (quiet_q == QC_W'(QUIET_CYC - 1)) begin
                  state_q <= RS_HALT;
               end else begin
                  quiet_q <= quiet_q + 1'b1;
               end
            end
            default: begin
               state_q <= RS_HALT;
            end
         endcase
      end
   end

   assign run_en  = (state_q == RS_RUN);
   assign stopped = (state_q == RS_HALT);

endmodule

// File: rtl/cfmon_cycle_ctr.sv
module cfmon_cycle_ctr #(
   parameter int CYC_W = 48,
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wdata,
   output logic [CYC_W-1:0] count
);

   localparam int HI_W = CYC_W - BUS_W;

   generate
      if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_width
         $error("cfmon_cycle_ctr: CYC_W must lie in (BUS_W, 2*BUS_W]");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr_lo) begin
         count[BUS_W-1:0] <= wdata;
      end else if (wr_hi) begin
         count[CYC_W-1:BUS_W] <= wdata[HI_W-1:0];
      end else if (inc) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/cfmon_bus_dec.sv
module cfmon_bus_dec
   import cfmon_pkg::*;
#(
   parameter int NUM_STAGES = 28
) (
   input  logic [$clog2(2*NUM_STAGES):0]    addr,
   output bus_kind_e                         kind,
   output logic [$clog2(NUM_STAGES)-1:0]     stage_idx,
   output logic                              stage_dir,
   output logic                              ctr_ring,
   output logic                              ctr_hi
);

   localparam int AW       = $clog2(2*NUM_STAGES) + 1;
   localparam int IDX_W    = $clog2(NUM_STAGES);
   localparam int WORDS    = 2 * NUM_STAGES;

   generate
      if (AW < 4) begin : g_bad_map
         $error("cfmon_bus_dec: stage map too small for counter window");
      end
   endgenerate

   always_comb begin
      stage_idx = IDX_W'(addr[AW-1:1]);
      stage_dir = addr[0];
      ctr_ring  = addr[1];
      ctr_hi    = addr[0];
      if (addr < AW'(WORDS)) begin
         kind = BK_STAGE;
      end else if (addr[AW-1] && (addr[AW-2:2] == '0)) begin
         kind = BK_CTR;
      end else begin
         kind = BK_NONE;
      end
   end

endmodule

// File: rtl/cfmon_top.sv
module cfmon_top
   import cfmon_pkg::*;
#(
   parameter int NUM_STAGES = 28,
   parameter int ITEM_AW    = 2,
   parameter int COUNT_W    = 5,
   parameter int CYC_W      = 48,
   parameter int BUS_W      = 32,
   parameter int MON_BITS   = 4,
   parameter int QUIET_CYC  = 2
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       run_req,
   output logic                                       run_en,
   output logic                                       stopped,
   input  logic                                       ring_grant_any,
   input  logic [1:0]                                 ring_cross,
   input  logic [1:0]                                 ring_cross_mark,
   input  logic [2*NUM_STAGES*(ITEM_AW+COUNT_W+2)-1:0] ring_state,
   output logic                                       stg_ld,
   output logic [$clog2(NUM_STAGES)-1:0]              stg_ld_idx,
   output logic                                       stg_ld_dir,
   output logic [ITEM_AW+COUNT_W+1:0]                 stg_ld_word,
   input  logic                                       bus_sel,
   input  logic                                       bus_we,
   input  logic [$clog2(2*NUM_STAGES):0]              bus_addr,
   input  logic [BUS_W-1:0]                           bus_wdata,
   output logic [BUS_W-1:0]                           bus_rdata,
   output logic                                       wr_err,
   output logic [MON_BITS-1:0]                        tap_n,
   output logic [MON_BITS-1:0]                        tap_s
);

   localparam int WORD_W = ITEM_AW + COUNT_W + 2;
   localparam int IDX_W  = $clog2(NUM_STAGES);
   localparam int HI_W   = CYC_W - BUS_W;

   generate
      if (WORD_W > BUS_W) begin : g_bad_word
         $error("cfmon_top: item word wider than bus");
      end
      if (MON_BITS < 1 || MON_BITS > CYC_W) begin : g_bad_tap
         $error("cfmon_top: MON_BITS out of range");
      end
   endgenerate

   // bus decode
   bus_kind_e          dec_kind;
   logic [IDX_W-1:0]   dec_idx;
   logic               dec_dir;
   logic               dec_ring;
   logic               dec_hi;

   cfmon_bus_dec #(.NUM_STAGES(NUM_STAGES)) u_dec (
      .addr      (bus_addr),
      .kind      (dec_kind),
      .stage_idx (dec_idx),
      .stage_dir (dec_dir),
      .ctr_ring  (dec_ring),
      .ctr_hi    (dec_hi)
   );

   // run / stop control
   cfmon_run_ctl #(.QUIET_CYC(QUIET_CYC)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_req   (run_req),
      .grant_any (ring_grant_any),
      .run_en    (run_en),
      .stopped   (stopped)
   );

   logic wr_req;
   logic wr_ok;
   assign wr_req = bus_sel && bus_we;
   assign wr_ok  = wr_req && stopped;

   // lap counters, one per ring
   logic [CYC_W-1:0] lap_q [NUM_RINGS];

   for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
      logic hit_ctr;
      assign hit_ctr = wr_ok && (dec_kind == BK_CTR) && (dec_ring == 1'(r));

      cfmon_cycle_ctr #(.CYC_W(CYC_W), .BUS_W(BUS_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ring_cross[r] && ring_cross_mark[r]),
         .wr_lo (hit_ctr && !dec_hi),
         .wr_hi (hit_ctr && dec_hi),
         .wdata (bus_wdata),
         .count (lap_q[r])
      );
   end

   assign tap_n = lap_q[RING_N][MON_BITS-1:0];
   assign tap_s = lap_q[RING_S][MON_BITS-1:0];

   // stage load strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_ld      <= 1'b0;
         stg_ld_idx  <= '0;
         stg_ld_dir  <= 1'b0;
         stg_ld_word <= '0;
      end else begin
         stg_ld <= wr_ok && (dec_kind == BK_STAGE);
         if (wr_ok && (dec_kind == BK_STAGE)) begin
            stg_ld_idx  <= dec_idx;
            stg_ld_dir  <= dec_dir;
            stg_ld_word <= bus_wdata[WORD_W-1:0];
         end
      end
   end

   // sticky error on blocked writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_err <= 1'b0;
      end else if (wr_req && !stopped) begin
         wr_err <= 1'b1;
      end
   end

   // read path
   logic [BUS_W-1:0] rd_mux;
   logic [CYC_W-1:0] rd_lap;

   always_comb begin
      rd_lap = lap_q[dec_ring];
      rd_mux = '0;
      unique case (dec_kind)
         BK_STAGE: rd_mux = BUS_W'(ring_state[{dec_idx, dec_dir}*WORD_W +: WORD_W]);
         BK_CTR:   rd_mux = dec_hi ? BUS_W'(rd_lap[CYC_W-1:CYC_W-HI_W])
                                   : rd_lap[BUS_W-1:0];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_sel && !bus_we) begin
         bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/cfmon_checker.sv
module cfmon_checker #(
   parameter int MON_BITS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                run_req,
   input logic                ring_grant_any,
   input logic                bus_sel,
   input logic                bus_we,
   input logic [1:0]          ring_cross,
   input logic [1:0]          ring_cross_mark,
   input logic                run_en,
   input logic                stopped,
   input logic                wr_err,
   input logic                stg_ld,
   input logic [MON_BITS-1:0] tap_n,
   input logic [MON_BITS-1:0] tap_s
);

   logic [MON_BITS-1:0] one_v;
   assign one_v = 1;

   // R4
   stop_drops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_req |=> !run_en);

   // R4
   quiet_before_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped) |-> (!$past(ring_grant_any) && !$past(ring_grant_any, 2) && !$past(run_req)));

   // R5
   start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_req |=> (run_en && !stopped));

   // R9
   blocked_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && !stopped) |=> wr_err);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> wr_err);

   // R6
   load_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_ld |-> $past(bus_sel && bus_we && stopped));

   // R2
   north_lap_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_cross[0] && ring_cross_mark[0] && !(bus_sel && bus_we)) |=> (tap_n == $past(tap_n) + one_v));

   // R3
   south_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ring_cross[1] && ring_cross_mark[1]) && !(bus_sel && bus_we)) |=> $stable(tap_s));

endmodule

bind cfmon_top cfmon_checker #(.MON_BITS(MON_BITS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .run_req         (run_req),
   .ring_grant_any  (ring_grant_any),
   .bus_sel         (bus_sel),
   .bus_we          (bus_we),
   .ring_cross      (ring_cross),
   .ring_cross_mark (ring_cross_mark),
   .run_en          (run_en),
   .stopped         (stopped),
   .wr_err          (wr_err),
   .stg_ld          (stg_ld),
   .tap_n           (tap_n),
   .tap_s           (tap_s)
);

// File: tb/cfmon_top_bench.sv
module cfmon_top_bench;

   localparam int NS     = 28;
   localparam int WW     = 9;
   localparam int NWORDS = 2 * NS;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 run_req = 1'b0;
   logic                 ring_grant_any = 1'b0;
   logic [1:0]           ring_cross = '0;
   logic [1:0]           ring_cross_mark = '0;
   logic [NWORDS*WW-1:0] ring_state;
   logic                 bus_sel = 1'b0;
   logic                 bus_we = 1'b0;
   logic [6:0]           bus_addr = '0;
   logic [31:0]          bus_wdata = '0;
   logic                 run_en, stopped, stg_ld, stg_ld_dir, wr_err;
   logic [4:0]           stg_ld_idx;
   logic [8:0]           stg_ld_word;
   logic [31:0]          bus_rdata;
   logic [3:0]           tap_n, tap_s;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cfmon_top u_cfmon_top (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .run_en(run_en), .stopped(stopped),
      .ring_grant_any(ring_grant_any), .ring_cross(ring_cross),
      .ring_cross_mark(ring_cross_mark), .ring_state(ring_state),
      .stg_ld(stg_ld), .stg_ld_idx(stg_ld_idx), .stg_ld_dir(stg_ld_dir),
      .stg_ld_word(stg_ld_word), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .wr_err(wr_err), .tap_n(tap_n), .tap_s(tap_s)
   );

   function automatic logic [8:0] pattern_word(input int k);
      return 9'((k * 37 + 5) & 16'h1FF);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic cross_pulse(input int r, input logic m);
      @(negedge clk);
      ring_cross[r] = 1'b1; ring_cross_mark[r] = m;
      @(negedge clk);
      ring_cross = '0; ring_cross_mark = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 stopped", stopped, 1);
      chk("R1 run_en", run_en, 0);
      chk("R1 wr_err", wr_err, 0);
      chk("R1 stg_ld", stg_ld, 0);
      bus_read(7'd64, d); chk("R1 north lo", d, 0);
      bus_read(7'd67, d); chk("R1 south hi", d, 0);
   endtask

   task automatic t_stage_write;
      bus_write(7'd55, 32'h1A5);
      chk("R6 ld pulse", stg_ld, 1);
      chk("R6 ld idx", stg_ld_idx, 27);
      chk("R6 ld dir", stg_ld_dir, 1);
      chk("R6 ld word", stg_ld_word, 9'h1A5);
      @(negedge clk);
      chk("R6 single pulse", stg_ld, 0);
      bus_write(7'd0, 32'hFFFF_FE03);
      chk("R6 idx0 idx", stg_ld_idx, 0);
      chk("R6 idx0 dir", stg_ld_dir, 0);
      chk("R6 idx0 word", stg_ld_word, 9'h003);
   endtask

   task automatic t_stage_read;
      logic [31:0] d;
      bus_read(7'd55, d); chk("R7 word55", d, {23'd0, pattern_word(55)});
      bus_read(7'd0,  d); chk("R7 word0",  d, {23'd0, pattern_word(0)});
      bus_read(7'd13, d); chk("R7 word13", d, {23'd0, pattern_word(13)});
   endtask

   task automatic t_ctr_access;
      logic [31:0] d;
      bus_write(7'd64, 32'h1234_5678);
      bus_write(7'd65, 32'h0001_ABCD);
      bus_read(7'd64, d); chk("R8 north lo", d, 32'h1234_5678);
      bus_read(7'd65, d); chk("R8 north hi", d, 32'h0000_ABCD);
      chk("R10 tap_n", tap_n, 4'h8);
      bus_write(7'd66, 32'hFFFF_FFFF);
      bus_write(7'd67, 32'h0000_0001);
      bus_read(7'd66, d); chk("R8 south lo", d, 32'hFFFF_FFFF);
      chk("R10 tap_s", tap_s, 4'hF);
      bus_write(7'd64, 32'h0);
      bus_write(7'd65, 32'h0);
   endtask

   task automatic t_run_count;
      logic [31:0] d;
      @(negedge clk); run_req = 1'b1;
      @(negedge clk);
      chk("R5 run_en", run_en, 1);
      chk("R5 stopped low", stopped, 0);
      for (int i = 0; i < 3; i++) cross_pulse(0, 1'b1);
      chk("R2 three laps", tap_n, 4'd3);
      cross_pulse(0, 1'b0);
      chk("R2 unmarked ignored", tap_n, 4'd3);
      bus_read(7'd64, d); chk("R2 north lo", d, 32'd3);
      bus_read(7'd66, d); chk("R3 south untouched", d, 32'hFFFF_FFFF);
      cross_pulse(1, 1'b1);
      bus_read(7'd66, d); chk("R11 wrap lo", d, 32'd0);
      bus_read(7'd67, d); chk("R11 carry hi", d, 32'd2);
      bus_read(7'd64, d); chk("R3 north untouched", d, 32'd3);
   endtask

   task automatic t_write_blocked;
      logic [31:0] d;
      bus_write(7'd64, 32'h55);
      chk("R9 err set", wr_err, 1);
      bus_write(7'd10, 32'h1FF);
      chk("R9 no load", stg_ld, 0);
      bus_read(7'd64, d); chk("R9 counter kept", d, 32'd3);
      chk("R9 err sticky", wr_err, 1);
   endtask

   task automatic t_stop;
      @(negedge clk); run_req = 1'b0; ring_grant_any = 1'b1;
      @(negedge clk);
      chk("R4 run_en drops", run_en, 0);
      chk("R4 not yet stopped", stopped, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R4 grants hold off", stopped, 0);
      ring_grant_any = 1'b0;
      @(negedge clk);
      chk("R4 one quiet cycle", stopped, 0);
      @(negedge clk);
      chk("R4 two quiet cycles", stopped, 1);
      chk("R9 err survives stop", wr_err, 1);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      bus_read(7'd60, d);  chk("R12 gap read", d, 0);
      bus_read(7'd100, d); chk("R12 high read", d, 0);
   endtask

   initial begin
      for (int k = 0; k < NWORDS; k++) ring_state[k*WW +: WW] = pattern_word(k);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stage_write();
      t_stage_read();
      t_ctr_access();
      t_run_count();
      t_write_blocked();
      t_stop();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule